// File: doc/BRIEF.md
# Masked Multi-CPU Device Interrupt Router

The router gathers up to 64 level-sensitive device request lines into one shared raw request word and steers it to four CPUs. Each CPU owns a private 64-bit enable mask, and each CPU's interrupt output is high whenever any raw request that its mask enables is active. One extra input stands for a cascaded legacy interrupt controller and always lands on raw bit 55. The device line 55 input plays no part.

Software uses a simple register port to do three things. It can read the raw word. It can read and write each CPU's mask. It can read each CPU's masked request view, which is read-only. A read is answered one cycle later by a small response state machine with three states:

- `RSP_IDLE`: no response is pending.
- `RSP_DATA`: a valid read is being answered.
- `RSP_FAULT`: a read of an unmapped offset is being answered with all ones and an error pulse.

The machine picks its next state on every edge. A read to a mapped offset moves it to `RSP_DATA`. A read to an unmapped offset moves it to `RSP_FAULT`. No read moves it to `RSP_IDLE`. These transitions apply from any state, so back-to-back reads are answered on consecutive cycles.

Top module: `irq_router_top`

## Requirements
- R1: Raw bit n (n not 55) is 1 while `dev_irq[n]` is high and returns to 0 when the line falls. Requests are not latched. The raw word is read at offset 0x300.
- R2: Raw bit 55 follows `legacy_irq`. `dev_irq[55]` has no effect on the raw word or on any CPU output.
- R3: The masked view of CPU k reads as mask k AND raw. The view offsets are 0x280, 0x2C0, 0x680 and 0x6C0 for CPUs 0 to 3.
- R4: Writes to the view offsets and to 0x300 change no register and no output.
- R5: `cpu_irq[k]` is 1 exactly when mask k AND raw is nonzero.
- R6: Each mask is read and written at 0x200, 0x240, 0x600 or 0x640 for CPUs 0 to 3. A write changes only the addressed CPU's mask.
- R7: `cpu_irq` reflects a request line change or a mask write after the second rising edge that follows it. After the first edge it still shows the old value.
- R8: Reset clears all masks, the raw word and `cpu_irq`.
- R9: A read of any other offset returns all ones with `reg_err` high for that one response cycle.
- R10: Each read asserted at a rising edge gives `reg_rvalid` for exactly the following cycle. The data is the register state at that edge. `reg_rvalid` is low when no read was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_irq | input | 64 | Device request lines, level sensitive |
| legacy_irq | input | 1 | Cascaded legacy controller request, drives raw bit 55 |
| reg_addr | input | 12 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read response valid |
| reg_err | output | 1 | Unmapped read indication |
| cpu_irq | output | 4 | One interrupt output per CPU |

## Verification
A read response is due in the cycle after the edge that samples the read strobe. The bench pushes the expected word into a queue when it raises the strobe. A monitor pops that word at the next falling edge on which `reg_rvalid` is high. CPU outputs lag a line change or a mask write by two rising edges. The bench therefore samples `cpu_irq` at falling edges only, once after the first edge to confirm the old value and once after the second edge to confirm the new one. Register reads are made only after inputs have been stable for two edges.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int CPU_COUNT = 4;
    localparam int OFS_W     = 12;
    localparam int CPU_SEL_W = $clog2(CPU_COUNT);

    typedef enum logic [1:0] {
        AK_NONE,
        AK_MASK,
        AK_VIEW,
        AK_RAW
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e            kind;
        logic [CPU_SEL_W-1:0] cpu;
    } acc_dec_t;

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_DATA,
        RSP_FAULT
    } rsp_state_e;

    function automatic acc_dec_t decode_ofs(input logic [OFS_W-1:0] ofs);
        acc_dec_t d;
        d.kind = AK_NONE;
        d.cpu  = '0;
        case (ofs)
            12'h200: begin d.kind = AK_MASK; d.cpu = 2'd0; end
            12'h240: begin d.kind = AK_MASK; d.cpu = 2'd1; end
            12'h600: begin d.kind = AK_MASK; d.cpu = 2'd2; end
            12'h640: begin d.kind = AK_MASK; d.cpu = 2'd3; end
            12'h280: begin d.kind = AK_VIEW; d.cpu = 2'd0; end
            12'h2C0: begin d.kind = AK_VIEW; d.cpu = 2'd1; end
            12'h680: begin d.kind = AK_VIEW; d.cpu = 2'd2; end
            12'h6C0: begin d.kind = AK_VIEW; d.cpu = 2'd3; end
            12'h300: begin d.kind = AK_RAW;  d.cpu = 2'd0; end
            default: begin d.kind = AK_NONE; d.cpu = 2'd0; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/irq_raw_capture.sv
module irq_raw_capture #(
    parameter int IRQ_W      = 64,
    parameter int LEGACY_BIT = 55
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] dev_irq,
    input  logic             legacy_irq,
    output logic [IRQ_W-1:0] raw_q
);

    logic [IRQ_W-1:0] merged;

    always_comb begin
        merged             = dev_irq;
        merged[LEGACY_BIT] = legacy_irq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= merged;
    end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int IRQ_W = 64,
    parameter int CPUS  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CPUS-1:0]            mask_wr,
    input  logic [IRQ_W-1:0]           wdata,
    input  logic [IRQ_W-1:0]           raw_q,
    output logic [CPUS-1:0][IRQ_W-1:0] mask_q,
    output logic [CPUS-1:0]            cpu_irq
);

    for (genvar k = 0; k < CPUS; k++) begin : g_cpu
        always_ff @(posedge clk) begin
            if (!rst_n)          mask_q[k] <= '0;
            else if (mask_wr[k]) mask_q[k] <= wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cpu_irq[k] <= 1'b0;
            else        cpu_irq[k] <= |(mask_q[k] & raw_q);
        end
    end

endmodule

// File: rtl/irq_csr_fsm.sv
module irq_csr_fsm
    import irq_router_pkg::*;
#(
    parameter int IRQ_W = 64,
    parameter int CPUS  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [OFS_W-1:0]           reg_addr,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [CPUS-1:0][IRQ_W-1:0] mask_q,
    input  logic [IRQ_W-1:0]           raw_q,
    output logic [CPUS-1:0]            mask_wr,
    output logic [IRQ_W-1:0]           reg_rdata,
    output logic                       reg_rvalid,
    output logic                       reg_err
);

    acc_dec_t         dec;
    rsp_state_e       state_q, state_d;
    logic [IRQ_W-1:0] rd_word;

    assign dec = decode_ofs(reg_addr);

    for (genvar k = 0; k < CPUS; k++) begin : g_wr
        assign mask_wr[k] = reg_wr && (dec.kind == AK_MASK) && (dec.cpu == CPU_SEL_W'(k));
    end

    always_comb begin
        case (dec.kind)
            AK_MASK: rd_word = mask_q[dec.cpu];
            AK_VIEW: rd_word = mask_q[dec.cpu] & raw_q;
            AK_RAW:  rd_word = raw_q;
            default: rd_word = '1;
        endcase
    end

    always_comb begin
        if (!reg_rd)                 state_d = RSP_IDLE;
        else if (dec.kind == AK_NONE) state_d = RSP_FAULT;
        else                          state_d = RSP_DATA;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_word;
    end

    always_comb begin
        unique case (state_q)
            RSP_IDLE:  begin reg_rvalid = 1'b0; reg_err = 1'b0; end
            RSP_DATA:  begin reg_rvalid = 1'b1; reg_err = 1'b0; end
            RSP_FAULT: begin reg_rvalid = 1'b1; reg_err = 1'b1; end
            default:   begin reg_rvalid = 1'b0; reg_err = 1'b0; end
        endcase
    end

endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
    import irq_router_pkg::*;
#(
    parameter int IRQ_W      = 64,
    parameter int LEGACY_BIT = 55
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IRQ_W-1:0]     dev_irq,
    input  logic                 legacy_irq,
    input  logic [OFS_W-1:0]     reg_addr,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [IRQ_W-1:0]     reg_wdata,
    output logic [IRQ_W-1:0]     reg_rdata,
    output logic                 reg_rvalid,
    output logic                 reg_err,
    output logic [CPU_COUNT-1:0] cpu_irq
);

    logic [IRQ_W-1:0]                raw_q;
    logic [CPU_COUNT-1:0][IRQ_W-1:0] mask_q;
    logic [CPU_COUNT-1:0]            mask_wr;

    irq_raw_capture #(.IRQ_W(IRQ_W), .LEGACY_BIT(LEGACY_BIT)) u_raw (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_irq    (dev_irq),
        .legacy_irq (legacy_irq),
        .raw_q      (raw_q)
    );

    irq_mask_bank #(.IRQ_W(IRQ_W), .CPUS(CPU_COUNT)) u_masks (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_wr (mask_wr),
        .wdata   (reg_wdata),
        .raw_q   (raw_q),
        .mask_q  (mask_q),
        .cpu_irq (cpu_irq)
    );

    irq_csr_fsm #(.IRQ_W(IRQ_W), .CPUS(CPU_COUNT)) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .mask_q     (mask_q),
        .raw_q      (raw_q),
        .mask_wr    (mask_wr),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .reg_err    (reg_err)
    );

endmodule

// File: rtl/irq_router_checker.sv
module irq_router_checker #(
    parameter int IRQ_W      = 64,
    parameter int LEGACY_BIT = 55,
    parameter int CPUS       = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [IRQ_W-1:0]           dev_irq,
    input logic                       legacy_irq,
    input logic                       reg_rd,
    input logic                       reg_wr,
    input logic [IRQ_W-1:0]           reg_rdata,
    input logic                       reg_rvalid,
    input logic                       reg_err,
    input logic [CPUS-1:0]            cpu_irq,
    input logic [IRQ_W-1:0]           raw_q,
    input logic [CPUS-1:0][IRQ_W-1:0] mask_q
);

    localparam logic [IRQ_W-1:0] LEG_ONE = IRQ_W'(1) << LEGACY_BIT;

    // R1 and R2: the raw word is last cycle's lines with bit 55 taken from the cascade
    p_raw_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> raw_q == (($past(dev_irq) & ~LEG_ONE) | ($past(legacy_irq) ? LEG_ONE : '0)));

    p_legacy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> raw_q[LEGACY_BIT] == $past(legacy_irq));

    // R5 and R7: each output follows mask AND raw one edge later
    for (genvar k = 0; k < CPUS; k++) begin : g_irq
        p_irq_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> cpu_irq[k] == |($past(mask_q[k]) & $past(raw_q)));
    end

    // R6: masks change only after a write
    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(reg_wr)) |-> $stable(mask_q));

    // R9: an error response carries all ones
    p_err_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> (reg_rvalid && reg_rdata == '1));

    // R10: a response only follows a read
    p_rvalid_after_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |-> $past(reg_rd));

endmodule

bind irq_router_top irq_router_checker #(
    .IRQ_W      (IRQ_W),
    .LEGACY_BIT (LEGACY_BIT),
    .CPUS       (irq_router_pkg::CPU_COUNT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_irq    (dev_irq),
    .legacy_irq (legacy_irq),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .reg_err    (reg_err),
    .cpu_irq    (cpu_irq),
    .raw_q      (raw_q),
    .mask_q     (mask_q)
);

// File: tb/tb_irq_router_top.sv
module tb_irq_router_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] dev_irq = '0;
    logic        legacy_irq = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        reg_rvalid;
    logic        reg_err;
    logic [3:0]  cpu_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [63:0] q_data[$];
    logic        q_err[$];
    string       q_tag[$];

    logic [63:0] m_mask [4];
    logic [11:0] MASK_OFS [4] = '{12'h200, 12'h240, 12'h600, 12'h640};
    logic [11:0] VIEW_OFS [4] = '{12'h280, 12'h2C0, 12'h680, 12'h6C0};

    irq_router_top dut (
        .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .legacy_irq(legacy_irq),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .reg_err(reg_err), .cpu_irq(cpu_irq)
    );

    always #10 clk = ~clk;

    function automatic logic [63:0] exp_raw();
        logic [63:0] r;
        r = dev_irq;
        r[55] = legacy_irq;
        return r;
    endfunction

    function automatic logic [3:0] exp_irq();
        logic [3:0] v;
        for (int k = 0; k < 4; k++) v[k] = |(m_mask[k] & exp_raw());
        return v;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_write(logic [11:0] a, logic [63:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        for (int k = 0; k < 4; k++) if (a == MASK_OFS[k]) m_mask[k] = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // issue a read; leaves the strobe high so reads can run back to back
    task automatic issue_read(string tag, logic [11:0] a, logic [63:0] d, logic e);
        reg_addr = a; reg_rd = 1'b1;
        q_data.push_back(d); q_err.push_back(e); q_tag.push_back(tag);
        @(negedge clk);
    endtask

    task automatic do_read(string tag, logic [11:0] a, logic [63:0] d, logic e);
        issue_read(tag, a, d, e);
        reg_rd = 1'b0;
        @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            if (q_data.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R10: actual unexpected response expected none");
            end else begin
                logic [63:0] d; logic e; string t;
                d = q_data.pop_front(); e = q_err.pop_front(); t = q_tag.pop_front();
                check({t, " data"}, reg_rdata, d);
                check({t, " err"}, 64'(reg_err), 64'(e));
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 4; k++) m_mask[k] = '0;
        idle(5);
        // R8: reset state
        check("R8 cpu_irq in reset", 64'(cpu_irq), 64'h0);
        rst_n = 1'b1;
        idle(2);
        check("R8 cpu_irq after reset", 64'(cpu_irq), 64'h0);
        do_read("R8 raw", 12'h300, 64'h0, 1'b0);
        do_read("R8 mask2", MASK_OFS[2], 64'h0, 1'b0);

        // R6: program masks and read them back
        do_write(MASK_OFS[0], 64'h0000_0000_0000_00F0);
        do_write(MASK_OFS[1], 64'hFFFF_FFFF_FFFF_FFFF);
        do_write(MASK_OFS[2], 64'h0080_0000_0000_0000);
        do_write(MASK_OFS[3], 64'h8000_0000_0000_0001);
        idle(2);
        for (int k = 0; k < 4; k++) do_read("R6 mask readback", MASK_OFS[k], m_mask[k], 1'b0);

        // R7 latency on a line change; R5 output value
        dev_irq = 64'h10;
        @(negedge clk);
        check("R7 old value after one edge", 64'(cpu_irq), 64'h0);
        @(negedge clk);
        check("R5 R7 new value after two edges", 64'(cpu_irq), 64'(exp_irq()));
        check("R5 cpu0/cpu1 asserted", 64'(cpu_irq), 64'h3);
        do_read("R1 raw line4", 12'h300, 64'h10, 1'b0);
        for (int k = 0; k < 4; k++) do_read("R3 view", VIEW_OFS[k], m_mask[k] & 64'h10, 1'b0);

        // R1: level tracking, drop the line
        dev_irq = '0;
        idle(2);
        check("R1 line low clears outputs", 64'(cpu_irq), 64'h0);
        do_read("R1 raw cleared", 12'h300, 64'h0, 1'b0);

        // R2: device line 55 ignored
        dev_irq = 64'h0080_0000_0000_0000;
        idle(2);
        check("R2 dev line 55 ignored", 64'(cpu_irq), 64'h0);
        do_read("R2 raw ignores dev55", 12'h300, 64'h0, 1'b0);
        dev_irq = '0;
        legacy_irq = 1'b1;
        idle(2);
        check("R2 legacy drives bit55", 64'(cpu_irq), 64'h6);
        do_read("R2 raw legacy", 12'h300, 64'h0080_0000_0000_0000, 1'b0);
        do_read("R3 view2 legacy", VIEW_OFS[2], 64'h0080_0000_0000_0000, 1'b0);

        // R5 with another pattern
        legacy_irq = 1'b0;
        dev_irq = 64'h8000_0000_0000_0001;
        idle(2);
        check("R5 cpu1/cpu3 asserted", 64'(cpu_irq), 64'hA);
        do_read("R3 view3", VIEW_OFS[3], 64'h8000_0000_0000_0001, 1'b0);
        do_read("R3 view0 empty", VIEW_OFS[0], 64'h0, 1'b0);

        // R4: writes to read-only offsets ignored
        do_write(VIEW_OFS[3], 64'h0);
        do_write(12'h300, 64'hFFFF_FFFF_FFFF_FFFF);
        idle(2);
        check("R4 outputs unchanged", 64'(cpu_irq), 64'hA);
        do_read("R4 view3 unchanged", VIEW_OFS[3], 64'h8000_0000_0000_0001, 1'b0);
        do_read("R4 raw unchanged", 12'h300, 64'h8000_0000_0000_0001, 1'b0);
        do_read("R4 mask3 unchanged", MASK_OFS[3], 64'h8000_0000_0000_0001, 1'b0);

        // R6 and R7: mask write affects only its CPU, two edges later
        do_write(MASK_OFS[3], 64'h0);
        check("R7 old value after mask write edge", 64'(cpu_irq), 64'hA);
        @(negedge clk);
        check("R6 only cpu3 dropped", 64'(cpu_irq), 64'h2);
        do_read("R6 mask1 untouched", MASK_OFS[1], 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        do_read("R6 mask0 untouched", MASK_OFS[0], 64'h0000_0000_0000_00F0, 1'b0);

        // R9: unmapped reads
        do_read("R9 unmapped 0x204", 12'h204, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        do_read("R9 unmapped 0x000", 12'h000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);

        // R10: back-to-back reads, then quiet
        issue_read("R10 b2b raw", 12'h300, 64'h8000_0000_0000_0001, 1'b0);
        issue_read("R10 b2b fault", 12'h7F8, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        issue_read("R10 b2b mask1", MASK_OFS[1], 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        reg_rd = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 no response when idle", 64'(reg_rvalid), 64'h0);
        check("R10 all responses seen", 64'(q_data.size()), 64'h0);

        finish_run();
    end

endmodule